// File: doc/BRIEF.md
# Nesting Vectored Interrupt Controller

This block gathers interrupt requests from synchronous internal sources and from asynchronous general-purpose input pins and latches them into a pending register. It filters them through a per-source enable mask and a control word that holds a master enable and a nesting enable. The lowest-numbered request that is both pending and enabled goes to a processor core as a request flag and a source index. The core accepts the request with a one-cycle acknowledge and signals the end of a handler with a one-cycle return pulse. The controller tracks which sources are in service and uses that record to decide whether a new request may interrupt the current handler.

Software reaches four 16-bit registers through a single-cycle read/write port. Through it, software can force or remove pending requests and choose, for each pin, how the pin raises a request: while it is high, on one selected edge, or on every change. Pin inputs pass through a two-stage synchronizer before any detection. Internal sources take indices 0 to N_INT-1, and pin j takes index N_INT+j.

Top module: `nest_vic`

## Requirements
- R1: After reset the control, pending, mask and trigger registers all read 0 and irq_req is low, so no request is served until software sets the master enable.
- R2: The control register sits at address 0. Bit 5 is the master enable and bit 4 is the nesting enable. All other bits read 0, and writes to them have no effect.
- R3: The pending register sits at address 1. Bit i is source i. A write replaces the latched bits, which sets or clears requests, and bits above the source count read 0.
- R4: The mask register sits at address 2. A 1 in bit i lets source i raise irq_req, and a pending source whose mask bit is 0 never raises irq_req.
- R5: While the master enable is 0, irq_req stays low whatever the pending and mask registers hold.
- R6: irq_vec gives the lowest index that is both pending and unmasked. An irq_ack while irq_req is high clears that pending bit at the same clock edge and puts that source in service.
- R7: With nesting disabled, irq_req stays low while any source is in service, until irq_ret ends the service.
- R8: With nesting enabled, irq_req rises only for a source whose index is below the lowest index in service. irq_ret ends the service of the lowest index in service.
- R9: Any cycle in which an internal request input is high sets its pending bit at the next clock edge. A request held high is pending again right after it is acknowledged.
- R10: The trigger register sits at address 3. Bits [2j+1:2j] give pin j's mode: 00 means level, 01 means single edge, and 1x means both edges. Bit 2*N_FLAG+j picks the single edge: 0 for rising, 1 for falling.
- R11: A pin change becomes visible in the pending register after the third rising clock edge that follows it. In level mode the bit cannot be cleared while the pin stays high.
- R12: An irq_ack while irq_req is low changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_req | input | N_INT | Internal request inputs, synchronous |
| gp_pin | input | N_FLAG | Asynchronous general-purpose request pins |
| reg_addr | input | 2 | Register select for reads and writes |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register, combinational |
| irq_req | output | 1 | A request is offered to the core |
| irq_vec | output | $clog2(N_INT+N_FLAG) | Index of the offered source |
| irq_ack | input | 1 | Core accepts the offered request |
| irq_ret | input | 1 | Core leaves the current handler |

## Verification
A wrong in-service record shows up at the ports as a request that appears or stays hidden at the wrong moment. This can be seen in the first cycle after the acknowledge or return that corrupted it. A bad pending or mask bit gives a wrong irq_vec or wrong read data in the cycle after the edge that wrote it. A fault in a pin detector gives a pending bit that appears early, appears late, appears twice or never appears, so the bench reads the pending register at the exact third edge and again some cycles later.

// File: rtl/nest_vic_pkg.sv
package nest_vic_pkg;

   localparam int REG_W = 16;

   typedef enum logic [1:0] {
      TRIG_LEVEL     = 2'b00,
      TRIG_ONE_EDGE  = 2'b01,
      TRIG_BOTH_EDGE = 2'b10,
      TRIG_BOTH_ALT  = 2'b11
   } trig_mode_e;

   localparam logic [1:0] ADDR_CTRL = 2'd0;
   localparam logic [1:0] ADDR_PEND = 2'd1;
   localparam logic [1:0] ADDR_MASK = 2'd2;
   localparam logic [1:0] ADDR_TRIG = 2'd3;

   localparam int CTRL_NEST_BIT = 4;
   localparam int CTRL_GLOB_BIT = 5;

   localparam logic [REG_W-1:0] CTRL_LIVE =
      (REG_W'(1) << CTRL_NEST_BIT) | (REG_W'(1) << CTRL_GLOB_BIT);

endpackage

// File: rtl/vic_first_set.sv
module vic_first_set #(
   parameter  int W  = 8,
   localparam int IW = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]  vec,
   output logic          any,
   output logic [IW-1:0] idx
);

   generate
      if (W < 2) begin : g_bad_width
         $error("vic_first_set: W must be at least 2");
      end
   endgenerate

   assign any = |vec;

   always_comb begin
      idx = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (vec[i]) idx = IW'(i);
      end
   end

endmodule

// File: rtl/vic_pin_sense.sv
module vic_pin_sense
   import nest_vic_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       pin,
   input  trig_mode_e mode,
   input  logic       falling,
   output logic       hit
);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;
   logic                   s_now;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("vic_pin_sense: SYNC_STAGES must be at least 2");
      end
   endgenerate

   assign s_now = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk) begin
      if (rst) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
         prev_q <= s_now;
      end
   end

   always_comb begin
      case (mode)
         TRIG_LEVEL:    hit = s_now;
         TRIG_ONE_EDGE: hit = falling ? (!s_now && prev_q) : (s_now && !prev_q);
         default:       hit = s_now ^ prev_q;
      endcase
   end

   // R10
   edge_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      (hit && mode == TRIG_ONE_EDGE)
      |=> !(hit && mode == TRIG_ONE_EDGE && falling == $past(falling)));

endmodule

// File: rtl/vic_service.sv
module vic_service #(
   parameter  int NSRC = 12,
   localparam int VW   = (NSRC > 1) ? $clog2(NSRC) : 1
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [NSRC-1:0] cand,
   input  logic            glob_en,
   input  logic            nest_en,
   input  logic            ack,
   input  logic            ret,
   output logic            req,
   output logic [VW-1:0]   vec,
   output logic [NSRC-1:0] take_hot
);

   logic [NSRC-1:0] isr_q, isr_d, ret_hot;
   logic            c_any, s_any, allow;
   logic [VW-1:0]   c_idx, s_idx;

   vic_first_set #(.W(NSRC)) u_cand (
      .vec (cand),
      .any (c_any),
      .idx (c_idx)
   );

   vic_first_set #(.W(NSRC)) u_serv (
      .vec (isr_q),
      .any (s_any),
      .idx (s_idx)
   );

   always_comb begin
      allow = 1'b0;
      if (glob_en && c_any) begin
         allow = !s_any || (nest_en && (c_idx < s_idx));
      end
   end

   assign req      = allow;
   assign vec      = c_idx;
   assign take_hot = (ack && allow) ? (NSRC'(1) << c_idx) : '0;
   assign ret_hot  = (ret && s_any) ? (NSRC'(1) << s_idx) : '0;
   assign isr_d    = (isr_q & ~ret_hot) | take_hot;

   always_ff @(posedge clk) begin
      if (rst) isr_q <= '0;
      else     isr_q <= isr_d;
   end

   // R6
   take_mark_chk: assert property (@(posedge clk) disable iff (rst)
      (ack && req) |=> isr_q[$past(vec)]);

   // R7
   no_nest_chk: assert property (@(posedge clk) disable iff (rst)
      (ack && req && !nest_en) |=> (!req || nest_en));

   // R8
   pop_one_chk: assert property (@(posedge clk) disable iff (rst)
      (ret && s_any && !(ack && req))
      |=> ($countones(isr_q) + 1 == $past($countones(isr_q))));

endmodule

// File: rtl/nest_vic.sv
module nest_vic
   import nest_vic_pkg::*;
#(
   parameter  int N_INT       = 8,
   parameter  int N_FLAG      = 4,
   parameter  int SYNC_STAGES = 2,
   localparam int NSRC        = N_INT + N_FLAG,
   localparam int VW          = (NSRC > 1) ? $clog2(NSRC) : 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [N_INT-1:0]  src_req,
   input  logic [N_FLAG-1:0] gp_pin,
   input  logic [1:0]        reg_addr,
   input  logic              reg_wr,
   input  logic [REG_W-1:0]  reg_wdata,
   output logic [REG_W-1:0]  reg_rdata,
   output logic              irq_req,
   output logic [VW-1:0]     irq_vec,
   input  logic              irq_ack,
   input  logic              irq_ret
);

   localparam int CFG_W = 3 * N_FLAG;

   generate
      if (N_INT < 1 || N_FLAG < 1) begin : g_bad_count
         $error("nest_vic: need at least one internal source and one pin");
      end
      if (NSRC > REG_W) begin : g_bad_nsrc
         $error("nest_vic: source count exceeds register width");
      end
      if (CFG_W > REG_W) begin : g_bad_cfg
         $error("nest_vic: trigger configuration exceeds register width");
      end
   endgenerate

   logic              nest_q, glob_q;
   logic [NSRC-1:0]   pend_q, mask_q, events, take_hot, cand;
   logic [CFG_W-1:0]  trig_q;
   logic [N_FLAG-1:0] pin_hit;
   logic              wr_ctrl, wr_pend, wr_mask, wr_trig;

   assign wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);
   assign wr_pend = reg_wr && (reg_addr == ADDR_PEND);
   assign wr_mask = reg_wr && (reg_addr == ADDR_MASK);
   assign wr_trig = reg_wr && (reg_addr == ADDR_TRIG);

   for (genvar j = 0; j < N_FLAG; j++) begin : g_pin
      vic_pin_sense #(.SYNC_STAGES(SYNC_STAGES)) u_sense (
         .clk     (clk),
         .rst     (rst),
         .pin     (gp_pin[j]),
         .mode    (trig_mode_e'(trig_q[2*j +: 2])),
         .falling (trig_q[2*N_FLAG + j]),
         .hit     (pin_hit[j])
      );
   end

   assign events = {pin_hit, src_req};
   assign cand   = pend_q & mask_q;

   vic_service #(.NSRC(NSRC)) u_service (
      .clk      (clk),
      .rst      (rst),
      .cand     (cand),
      .glob_en  (glob_q),
      .nest_en  (nest_q),
      .ack      (irq_ack),
      .ret      (irq_ret),
      .req      (irq_req),
      .vec      (irq_vec),
      .take_hot (take_hot)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         nest_q <= 1'b0;
         glob_q <= 1'b0;
         pend_q <= '0;
         mask_q <= '0;
         trig_q <= '0;
      end else begin
         if (wr_ctrl) begin
            nest_q <= reg_wdata[CTRL_NEST_BIT];
            glob_q <= reg_wdata[CTRL_GLOB_BIT];
         end
         if (wr_mask) mask_q <= reg_wdata[NSRC-1:0];
         if (wr_trig) trig_q <= reg_wdata[CFG_W-1:0];
         pend_q <= ((wr_pend ? reg_wdata[NSRC-1:0] : pend_q) & ~take_hot) | events;
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         ADDR_CTRL: begin
            reg_rdata[CTRL_NEST_BIT] = nest_q;
            reg_rdata[CTRL_GLOB_BIT] = glob_q;
         end
         ADDR_PEND: reg_rdata[NSRC-1:0]  = pend_q;
         ADDR_MASK: reg_rdata[NSRC-1:0]  = mask_q;
         default:   reg_rdata[CFG_W-1:0] = trig_q;
      endcase
   end

   // R1
   rst_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !irq_req);

   // R2
   ctrl_rsvd_chk: assert property (@(posedge clk) disable iff (rst)
      (reg_addr == ADDR_CTRL) |-> ((reg_rdata & ~CTRL_LIVE) == '0));

   // R5
   glob_off_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_ctrl && !reg_wdata[CTRL_GLOB_BIT]) |=> !irq_req);

   // R4
   vec_live_chk: assert property (@(posedge clk) disable iff (rst)
      irq_req |-> (pend_q[irq_vec] && mask_q[irq_vec]));

   // R6
   ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (irq_ack && irq_req && !wr_pend && !events[irq_vec])
      |=> !pend_q[$past(irq_vec)]);

   // R9
   int_latch_chk: assert property (@(posedge clk) disable iff (rst)
      (|src_req) |=> ((pend_q[N_INT-1:0] & $past(src_req)) == $past(src_req)));

endmodule

// File: tb/nest_vic_tb.sv
module nest_vic_tb;

   localparam int NI = 8;
   localparam int NF = 4;
   localparam int NS = NI + NF;
   localparam int VW = $clog2(NS);

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [NI-1:0] src_req = '0;
   logic [NF-1:0] gp_pin = '0;
   logic [1:0]    reg_addr = '0;
   logic          reg_wr = 1'b0;
   logic [15:0]   reg_wdata = '0;
   logic [15:0]   reg_rdata;
   logic          irq_req;
   logic [VW-1:0] irq_vec;
   logic          irq_ack = 1'b0;
   logic          irq_ret = 1'b0;

   int  total = 0;
   int  bad   = 0;
   bit  done  = 1'b0;

   logic [NS-1:0] m_pend, m_mask, m_isr;
   logic          m_glob, m_nest;

   always #5 clk = ~clk;

   nest_vic #(.N_INT(NI), .N_FLAG(NF)) u_dut (
      .clk       (clk),
      .rst       (rst),
      .src_req   (src_req),
      .gp_pin    (gp_pin),
      .reg_addr  (reg_addr),
      .reg_wr    (reg_wr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .irq_req   (irq_req),
      .irq_vec   (irq_vec),
      .irq_ack   (irq_ack),
      .irq_ret   (irq_ret)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic ticks(input int n);
      for (int k = 0; k < n; k++) tick();
   endtask

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      reg_addr  = a;
      reg_wdata = d;
      reg_wr    = 1'b1;
      tick();
      reg_wr    = 1'b0;
   endtask

   task automatic rd_chk(input logic [1:0] a, input logic [15:0] exp, input string tag);
      reg_addr = a;
      #1;
      check(tag, {16'h0, reg_rdata}, {16'h0, exp});
   endtask

   task automatic pulse_ack();
      irq_ack = 1'b1;
      tick();
      irq_ack = 1'b0;
   endtask

   task automatic pulse_ret();
      irq_ret = 1'b1;
      tick();
      irq_ret = 1'b0;
   endtask

   task automatic irq_chk(input logic exp_req, input int exp_vec, input string tag);
      check({tag, " req"}, {31'h0, irq_req}, {31'h0, exp_req});
      if (exp_req) check({tag, " vec"}, {28'h0, irq_vec}, exp_vec);
   endtask

   function automatic int first_set(input logic [NS-1:0] v);
      for (int i = 0; i < NS; i++) if (v[i]) return i;
      return -1;
   endfunction

   function automatic bit model_req();
      int ci;
      int si;
      ci = first_set(m_pend & m_mask);
      si = first_set(m_isr);
      return m_glob && (ci >= 0) && ((si < 0) || (m_nest && ci < si));
   endfunction

   task automatic model_step(input logic [NI-1:0] rq, input logic ack, input logic ret,
                             input logic wr_en, input logic [1:0] a, input logic [15:0] d);
      int ci;
      int si;
      bit take;
      logic [NS-1:0] np;
      logic [NS-1:0] ni;
      ci   = first_set(m_pend & m_mask);
      si   = first_set(m_isr);
      take = ack && model_req();
      ni   = m_isr;
      if (ret && si >= 0) ni[si] = 1'b0;
      if (take) ni[ci] = 1'b1;
      np = (wr_en && a == 2'd1) ? d[NS-1:0] : m_pend;
      if (take) np[ci] = 1'b0;
      np = np | {{NF{1'b0}}, rq};
      if (wr_en && a == 2'd0) begin
         m_glob = d[5];
         m_nest = d[4];
      end
      if (wr_en && a == 2'd2) m_mask = d[NS-1:0];
      m_pend = np;
      m_isr  = ni;
   endtask

   function automatic logic [15:0] model_rd(input logic [1:0] a);
      case (a)
         2'd0:    return {10'h0, m_glob, m_nest, 4'h0};
         2'd1:    return {4'h0, m_pend};
         default: return {4'h0, m_mask};
      endcase
   endfunction

   task automatic do_reset();
      rst = 1'b1;
      ticks(3);
      rst = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog R1 act=running exp=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      @(negedge clk);
      do_reset();

      // R1: reset state
      rd_chk(2'd0, 16'h0000, "R1 ctrl after reset");
      rd_chk(2'd1, 16'h0000, "R1 pend after reset");
      rd_chk(2'd2, 16'h0000, "R1 mask after reset");
      rd_chk(2'd3, 16'h0000, "R1 trig after reset");
      irq_chk(1'b0, 0, "R1 idle");

      // R2: only two live control bits
      wr(2'd0, 16'hFFFF);
      rd_chk(2'd0, 16'h0030, "R2 reserved read zero");
      wr(2'd0, 16'h0000);

      // R3 / R4 / R5
      wr(2'd1, 16'h0028);
      rd_chk(2'd1, 16'h0028, "R3 pend forced");
      wr(2'd0, 16'h0020);
      irq_chk(1'b0, 0, "R4 masked off");
      wr(2'd2, 16'h0FFF);
      irq_chk(1'b1, 3, "R6 lowest first");
      wr(2'd0, 16'h0000);
      irq_chk(1'b0, 0, "R5 master off");

      // R12: ack without request
      pulse_ack();
      rd_chk(2'd1, 16'h0028, "R12 ack ignored");

      // R7: no nesting
      wr(2'd0, 16'h0020);
      irq_chk(1'b1, 3, "R7 offered");
      pulse_ack();
      rd_chk(2'd1, 16'h0020, "R6 ack clears bit");
      irq_chk(1'b0, 0, "R7 busy lower");
      wr(2'd1, 16'h0022);
      irq_chk(1'b0, 0, "R7 busy higher");
      pulse_ret();
      irq_chk(1'b1, 1, "R7 after return");

      // R8: nesting
      wr(2'd0, 16'h0030);
      irq_chk(1'b1, 1, "R8 idle offer");
      pulse_ack();
      irq_chk(1'b0, 0, "R8 lower blocked");
      wr(2'd1, 16'h0021);
      irq_chk(1'b1, 0, "R8 preempt");
      pulse_ack();
      irq_chk(1'b0, 0, "R8 two deep");
      pulse_ret();
      irq_chk(1'b0, 0, "R8 pop inner");
      pulse_ret();
      irq_chk(1'b1, 5, "R8 pop outer");
      pulse_ack();
      pulse_ret();
      irq_chk(1'b0, 0, "R8 drained");
      wr(2'd0, 16'h0000);

      // R9: internal request held high
      src_req[6] = 1'b1;
      tick();
      rd_chk(2'd1, 16'h0040, "R9 latched");
      wr(2'd0, 16'h0020);
      irq_chk(1'b1, 6, "R9 offered");
      pulse_ack();
      rd_chk(2'd1, 16'h0040, "R9 re-pended");
      src_req[6] = 1'b0;
      pulse_ret();
      wr(2'd1, 16'h0000);
      rd_chk(2'd1, 16'h0000, "R3 cleared");
      wr(2'd0, 16'h0000);
      wr(2'd1, 16'hFFFF);
      rd_chk(2'd1, 16'h0FFF, "R3 upper bits zero");
      wr(2'd1, 16'h0000);

      // R11: level pin 0 (source 8)
      gp_pin[0] = 1'b1;
      ticks(2);
      rd_chk(2'd1, 16'h0000, "R11 level not yet");
      tick();
      rd_chk(2'd1, 16'h0100, "R11 level third edge");
      wr(2'd1, 16'h0000);
      rd_chk(2'd1, 16'h0100, "R11 level held");
      gp_pin[0] = 1'b0;
      ticks(3);
      wr(2'd1, 16'h0000);
      rd_chk(2'd1, 16'h0000, "R11 level released");

      // R10: rising single edge, pin 1 (source 9)
      wr(2'd3, 16'h0004);
      rd_chk(2'd3, 16'h0004, "R10 trig readback");
      gp_pin[1] = 1'b1;
      ticks(2);
      rd_chk(2'd1, 16'h0000, "R10 rise not yet");
      tick();
      rd_chk(2'd1, 16'h0200, "R10 rise seen");
      wr(2'd1, 16'h0000);
      ticks(3);
      rd_chk(2'd1, 16'h0000, "R10 rise once");
      gp_pin[1] = 1'b0;
      ticks(4);
      rd_chk(2'd1, 16'h0000, "R10 rise ignores fall");

      // R10: falling single edge, pin 2 (source 10)
      wr(2'd3, 16'h0410);
      gp_pin[2] = 1'b1;
      ticks(4);
      rd_chk(2'd1, 16'h0000, "R10 fall ignores rise");
      gp_pin[2] = 1'b0;
      ticks(2);
      rd_chk(2'd1, 16'h0000, "R10 fall not yet");
      tick();
      rd_chk(2'd1, 16'h0400, "R10 fall seen");
      wr(2'd1, 16'h0000);

      // R10: both edges, pin 3 (source 11)
      wr(2'd3, 16'h0080);
      gp_pin[3] = 1'b1;
      ticks(3);
      rd_chk(2'd1, 16'h0800, "R10 dual rise");
      wr(2'd1, 16'h0000);
      gp_pin[3] = 1'b0;
      ticks(3);
      rd_chk(2'd1, 16'h0800, "R10 dual fall");

      // Random phase against the bench model (R3 R4 R5 R6 R7 R8 R9 R12)
      gp_pin = '0;
      do_reset();
      m_pend = '0;
      m_mask = '0;
      m_isr  = '0;
      m_glob = 1'b0;
      m_nest = 1'b0;
      for (int n = 0; n < 4000; n++) begin
         src_req   = ($urandom % 8 == 0) ? NI'($urandom) : '0;
         irq_ack   = ($urandom % 3 == 0);
         irq_ret   = ($urandom % 5 == 0);
         reg_wr    = ($urandom % 8 == 0);
         reg_addr  = 2'($urandom % 3);
         reg_wdata = 16'($urandom);
         if (reg_addr == 2'd0) reg_wdata[5] = ($urandom % 4 != 0);
         @(posedge clk);
         model_step(src_req, irq_ack, irq_ret, reg_wr, reg_addr, reg_wdata);
         @(negedge clk);
         irq_chk(model_req(), first_set(m_pend & m_mask), "R6 R7 R8 random");
         check("R3 R4 random read", {16'h0, reg_rdata}, {16'h0, model_rd(reg_addr)});
      end
      src_req = '0;
      irq_ack = 1'b0;
      irq_ret = 1'b0;
      reg_wr  = 1'b0;
      tick();

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule